// File: doc/BRIEF.md
# CPU-Guaranteed Bus Grant Arbiter

This block shares one bus between a host CPU and a set of peripheral bus masters. Every requester drives a request line and receives a grant line. At most one grant is high at a time. A grant is held until its owner pulses a completion strobe, so arbitration only takes place at a completion or while the bus sits idle. Among the peripheral masters a fixed order applies: the lowest index wins.

A 2-bit rotation setting bounds how long peripheral traffic can keep the CPU waiting. With the setting at zero there is no bound, and the CPU is served only when no peripheral master is asking. With settings 1, 2 and 3 the CPU is placed on the bus after that many consecutive peripheral grants. This holds even when peripheral requests never stop. A small saturating counter tracks the peripheral grants made since the CPU last had its turn.

Top module: `cpu_fair_arbiter`

## Requirements
- R1: While reset is asserted, and right after it is released, every grant output is low and the peripheral-grant count is zero.
- R2: In every cycle, at most one of cpu_gnt and the per_gnt bits is high.
- R3: While a grant is held and xfer_done is low, all grant outputs keep their values. A new grant appears in the cycle after the edge at which xfer_done is high, or after an edge with no grant held.
- R4: Among requesting peripheral masters, the grant goes to the lowest index. Index 0 ranks first.
- R5: With rot_mode = 2'b00, the CPU is granted at a decision only if no peripheral master is requesting. Continuous peripheral requests then hold the CPU off indefinitely.
- R6: With rot_mode = 2'b01, a requesting CPU is granted at the decision after every single peripheral grant.
- R7: With rot_mode = 2'b10, a requesting CPU is granted after two consecutive peripheral grants. Both go to the highest-ranked requester.
- R8: With rot_mode = 2'b11, a requesting CPU is granted after three consecutive peripheral grants.
- R9: If the CPU is not requesting when its turn arrives, the count restarts and a peripheral master is granted. That grant counts as the first of the new run.
- R10: A change of rot_mode never ends the current grant early. The new value governs the next decision, including any count built up under the old value.
- R11: With no grant held and no request present, the bus stays idle, and a completion strobe has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rot_mode | input | 2 | CPU rotation setting: 0 none, 1/2/3 peripheral grants per CPU turn |
| cpu_req | input | 1 | CPU bus request |
| per_req | input | NUM_PERIPH | Peripheral master requests, bit 0 highest priority |
| xfer_done | input | 1 | Completion pulse from the current bus owner |
| cpu_gnt | output | 1 | CPU bus grant |
| per_gnt | output | NUM_PERIPH | One-hot peripheral master grants |

## Verification
Two events can fall in the same cycle: a completion pulse that starts a new decision, and a change of rot_mode. The bench changes rot_mode while a peripheral grant is held, and checks that the grant survives until the pulse. It also lets a count built up in mode 0 meet a switch to mode 1 exactly at a completion edge, and expects the CPU to win at once. A second case in which the CPU's turn meets a dropped CPU request is judged by whether the CPU wins after exactly one more peripheral grant.

// File: rtl/cpu_fair_arbiter.sv
module cpu_fair_arbiter #(
  parameter int NUM_PERIPH = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            rot_mode,
  input  logic                  cpu_req,
  input  logic [NUM_PERIPH-1:0] per_req,
  input  logic                  xfer_done,
  output logic                  cpu_gnt,
  output logic [NUM_PERIPH-1:0] per_gnt
);

  logic [1:0]            run_cnt;
  logic [NUM_PERIPH-1:0] per_pick;
  logic                  busy, decide, per_any, cpu_turn, take_cpu;

  assign busy     = cpu_gnt | (|per_gnt);
  assign decide   = !busy || xfer_done;
  assign per_any  = |per_req;
  assign cpu_turn = (rot_mode != 2'b00) && (run_cnt >= rot_mode);
  assign take_cpu = cpu_req && (cpu_turn || !per_any);

  always_comb begin
    per_pick = '0;
    for (int i = NUM_PERIPH - 1; i >= 0; i--) begin
      if (per_req[i]) begin
        per_pick    = '0;
        per_pick[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_gnt <= 1'b0;
      per_gnt <= '0;
      run_cnt <= 2'd0;
    end else if (decide) begin
      cpu_gnt <= take_cpu;
      per_gnt <= take_cpu ? '0 : per_pick;
      if (take_cpu)
        run_cnt <= 2'd0;
      else if (per_any)
        run_cnt <= cpu_turn ? 2'd1 : ((run_cnt == 2'd3) ? 2'd3 : 2'(run_cnt + 2'd1));
    end
  end

  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cpu_gnt, per_gnt})); // R2

  AST_HOLD_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !xfer_done) |=> $stable({cpu_gnt, per_gnt})); // R3

  AST_TOP_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    (rot_mode == 2'b00 && per_req[0] && (!busy || xfer_done)) |=> per_gnt[0]); // R4

  AST_NO_GUARANTEE: assert property (@(posedge clk) disable iff (!rst_n)
    (rot_mode == 2'b00 && per_any && (!busy || xfer_done)) |=> !cpu_gnt); // R5

  AST_CPU_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
    (rot_mode == 2'b01 && (|per_gnt) && xfer_done && cpu_req) |=> cpu_gnt); // R6

  AST_IDLE_STAY: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cpu_req && !per_any) |=> !(cpu_gnt || (|per_gnt))); // R11

endmodule

// File: tb/tb_cpu_fair_arbiter.sv
module tb_cpu_fair_arbiter;
  localparam int CLK_P = 10;
  localparam int NP = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [1:0]    rot_mode = 2'b00;
  logic          cpu_req = 1'b0;
  logic [NP-1:0] per_req = '0;
  logic          xfer_done = 1'b0;
  logic          cpu_gnt;
  logic [NP-1:0] per_gnt;

  int checks = 0;
  int errors = 0;
  logic [NP:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_P/2) clk = ~clk;

  cpu_fair_arbiter #(.NUM_PERIPH(NP)) dut (
    .clk(clk), .rst_n(rst_n), .rot_mode(rot_mode), .cpu_req(cpu_req),
    .per_req(per_req), .xfer_done(xfer_done), .cpu_gnt(cpu_gnt), .per_gnt(per_gnt));

  task automatic check(input string tag, input logic [NP:0] act, input logic [NP:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input logic [1:0] m, input logic c, input logic [NP-1:0] p,
                      input logic d, input logic [NP:0] e, input string tag);
    @(negedge clk);
    rot_mode  = m;
    cpu_req   = c;
    per_req   = p;
    xfer_done = d;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (exp_q.size() > 0) begin
        logic [NP:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {cpu_gnt, per_gnt}, e);
        check("R2 one grant", {4'b0, $countones({cpu_gnt, per_gnt}) <= 1}, 5'b00001);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P*2 + 1);
    check("R1 reset grants", {cpu_gnt, per_gnt}, 5'b00000);
    @(negedge clk);
    rst_n = 1'b1;
    step(2'b00, 0, 4'b0000, 0, 5'b00000, "R11 idle stays idle");
    step(2'b00, 0, 4'b0000, 1, 5'b00000, "R11 done while idle ignored");
    step(2'b00, 1, 4'b0110, 0, 5'b00010, "R4 index1 over index2");
    step(2'b00, 1, 4'b0111, 0, 5'b00010, "R3 hold without done");
    step(2'b00, 1, 4'b0111, 1, 5'b00001, "R4 index0 wins");
    step(2'b00, 1, 4'b0000, 1, 5'b10000, "R5 cpu only when no peripheral");
    step(2'b01, 1, 4'b1000, 1, 5'b01000, "R6 peripheral after cpu");
    step(2'b01, 1, 4'b1111, 0, 5'b01000, "R3 hold in mode 01");
    step(2'b01, 1, 4'b1111, 1, 5'b10000, "R6 cpu after one peripheral");
    step(2'b01, 1, 4'b1111, 1, 5'b00001, "R6 peripheral after cpu turn");
    step(2'b01, 1, 4'b1111, 1, 5'b10000, "R6 cpu again");
    step(2'b10, 1, 4'b1100, 1, 5'b00100, "R7 first peripheral");
    step(2'b10, 1, 4'b1100, 1, 5'b00100, "R7 second peripheral");
    step(2'b10, 1, 4'b1100, 1, 5'b10000, "R7 cpu after two");
    step(2'b11, 1, 4'b0011, 1, 5'b00001, "R8 first peripheral");
    step(2'b11, 1, 4'b0011, 1, 5'b00001, "R8 second peripheral");
    step(2'b11, 1, 4'b0011, 1, 5'b00001, "R8 third peripheral");
    step(2'b11, 1, 4'b0011, 1, 5'b10000, "R8 cpu after three");
    step(2'b01, 0, 4'b0100, 1, 5'b00100, "R9 peripheral grant");
    step(2'b01, 0, 4'b0100, 1, 5'b00100, "R9 skipped cpu turn");
    step(2'b01, 1, 4'b0100, 1, 5'b10000, "R9 restarted count");
    step(2'b01, 1, 4'b0001, 1, 5'b00001, "R10 setup grant");
    step(2'b00, 1, 4'b0001, 0, 5'b00001, "R10 mode change keeps grant");
    step(2'b11, 1, 4'b0001, 0, 5'b00001, "R10 second change keeps grant");
    step(2'b11, 1, 4'b0001, 1, 5'b00001, "R10 new mode governs decision");
    step(2'b11, 0, 4'b0000, 1, 5'b00000, "R11 release to idle");
    step(2'b11, 0, 4'b0000, 0, 5'b00000, "R11 idle holds");
    step(2'b11, 1, 4'b0000, 0, 5'b10000, "R3 idle grant to cpu");
    step(2'b00, 1, 4'b1000, 1, 5'b01000, "R5 peripheral first");
    step(2'b00, 1, 4'b1000, 1, 5'b01000, "R5 cpu held off 2");
    step(2'b00, 1, 4'b1000, 1, 5'b01000, "R5 cpu held off 3");
    step(2'b00, 1, 4'b1000, 1, 5'b01000, "R5 cpu held off 4");
    step(2'b01, 1, 4'b1000, 1, 5'b10000, "R10 mode switch at completion");
    @(posedge clk);
    #(CLK_P/2);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 reset mid grant", {cpu_gnt, per_gnt}, 5'b00000);
    @(negedge clk);
    rst_n = 1'b1;
    rot_mode = 2'b01;
    cpu_req = 1'b1;
    per_req = 4'b0010;
    xfer_done = 1'b0;
    @(posedge clk);
    #(CLK_P/4);
    check("R1 count cleared after reset", {cpu_gnt, per_gnt}, 5'b00010);
    @(negedge clk);
    xfer_done = 1'b1;
    @(posedge clk);
    #(CLK_P/4);
    check("R1 cpu after one grant from zero", {cpu_gnt, per_gnt}, 5'b10000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule